// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many clock cycles and leaves its answer in a pair of dedicated result registers called HI and LO. A single-cycle start pulse, qualified by a two-bit operation code, launches one of four operations: signed multiply, unsigned multiply, signed divide or unsigned divide. The unit then resolves one operand bit per cycle. A multiply uses shift-and-add and a divide uses restoring subtraction. Busy stays high for the whole run. When busy falls, a multiply has left its full 64-bit product split across the pair. A divide has left the quotient in LO and the remainder in HI.

Signed operations first reduce both operands to magnitudes. The signs are applied again when the result is written. Quotients truncate toward zero, and a remainder carries the sign of the dividend. No operation raises an exception. Dividing by zero gives a value that is not defined, but the run still ends on time.

Both registers are always visible on read ports. While the unit is idle, each one can be loaded directly from a shared data input. During a run the registers keep their previous contents. Move-to requests and further start pulses are ignored during a run.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, busy_o is 0 and both hi_o and lo_o read 0.
- R2: A start_i pulse sampled while idle launches the operation chosen by op_i, where 00 means signed multiply, 01 unsigned multiply, 10 signed divide and 11 unsigned divide. busy_o is high for exactly 32 cycles. hi_o and lo_o take the result at the same clock edge at which busy_o falls.
- R3: Unsigned multiply leaves bits 63..32 of the 64-bit product in HI and bits 31..0 in LO.
- R4: Signed multiply treats both operands as two's complement and leaves the 64-bit two's-complement product in HI (upper half) and LO (lower half).
- R5: Unsigned divide leaves the quotient in LO and the remainder in HI.
- R6: Signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. The case 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A divide with a zero divisor still completes after 32 busy cycles and returns to idle. Its HI and LO values are not defined.
- R8: While idle, wr_hi_i loads wr_data_i into HI and wr_lo_i loads it into LO at the next clock edge. Both may be used in the same cycle.
- R9: A move-to request made while busy_o is high changes neither HI nor LO.
- R10: A start_i pulse while busy_o is high is ignored. The running operation keeps its operands and its 32-cycle length.
- R11: While busy_o is high, hi_o and lo_o keep the values they held before the operation started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, taken only while idle |
| op_i | input | 2 | Operation code: bit 1 selects divide, bit 0 selects unsigned |
| a_i | input | 32 | First operand (multiplicand or dividend) |
| b_i | input | 32 | Second operand (multiplier or divisor) |
| wr_hi_i | input | 1 | Load HI from wr_data_i while idle |
| wr_lo_i | input | 1 | Load LO from wr_data_i while idle |
| wr_data_i | input | 32 | Value for move-to requests |
| busy_o | output | 1 | High while an operation is iterating |
| hi_o | output | 32 | Current HI contents |
| lo_o | output | 32 | Current LO contents |

## Verification
The assertions assume that start_i, op_i and the operands are stable values sampled at a clock edge. They also assume that operands are meaningful only in the cycle a start is accepted, because the unit captures them then and ignores them for the rest of the run. The stimulus drives every input half a cycle away from the active edge. It holds start_i for one cycle only. It injects extra starts and move-to requests only in the middle of a run, where the design must ignore them. Random operands come from a seeded generator and are mixed with fixed corner values: the most negative number, minus one, all-ones and zero divisors. Values are checked only for the non-zero-divisor cases, where the result is defined.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } md_op_e;

    // sign repair to apply when the raw magnitude result is written
    typedef struct packed {
        logic is_div;
        logic neg_lo;
        logic neg_hi;
    } md_fix_t;

endpackage

// File: rtl/md_prep.sv
module md_prep
    import md_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output md_fix_t      fix_o
);

    logic is_signed;
    logic neg_a;
    logic neg_b;

    always_comb begin
        is_signed    = ~op_i[0];
        neg_a        = is_signed & a_i[W-1];
        neg_b        = is_signed & b_i[W-1];
        mag_a_o      = neg_a ? (W'(0) - a_i) : a_i;
        mag_b_o      = neg_b ? (W'(0) - b_i) : b_i;
        fix_o.is_div = op_i[1];
        fix_o.neg_lo = neg_a ^ neg_b;
        fix_o.neg_hi = op_i[1] ? neg_a : (neg_a ^ neg_b);
    end

endmodule

// File: rtl/md_engine.sv
module md_engine
    import md_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   mag_a_i,
    input  logic [W-1:0]   mag_b_i,
    input  md_fix_t        fix_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] raw_o,
    output md_fix_t        fix_o
);

    localparam int CW = $clog2(W);
    localparam int W2 = 2 * W;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        md_fix_t       fix;
        logic [W-1:0]  opnd;
        logic [W2-1:0] acc;
    } eng_t;

    eng_t q, d;
    logic [W2-1:0] step_acc;
    logic [W:0]    sum;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    // one iteration: acc = {upper, lower}; mul shifts right, div shifts left
    always_comb begin
        sum   = {1'b0, q.acc[W2-1:W]} + (q.acc[0] ? {1'b0, q.opnd} : '0);
        trial = {q.acc[W2-1:W], q.acc[W-1]};
        diff  = trial - {1'b0, q.opnd};
        fits  = trial >= {1'b0, q.opnd};
        if (q.fix.is_div) begin
            step_acc = {(fits ? diff[W-1:0] : trial[W-1:0]), q.acc[W-2:0], fits};
        end else begin
            step_acc = {sum, q.acc[W-1:1]};
        end
    end

    always_comb begin
        d = q;
        if (load_i && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.fix  = fix_i;
            d.opnd = mag_b_i;
            d.acc  = {{W{1'b0}}, mag_a_i};
        end else if (q.busy) begin
            d.acc = step_acc;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = q.busy;
    assign done_o = q.busy && (q.cnt == LAST);
    assign raw_o  = step_acc;
    assign fix_o  = q.fix;

    // R2: a run keeps counting up until its last iteration
    p_run_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.cnt != LAST) |=> (q.busy && q.cnt == $past(q.cnt) + 1'b1));

    // R2: the last iteration returns the engine to idle
    p_last_goes_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !q.busy);

    // R2: an accepted load starts counting from zero
    p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !q.busy) |=> (q.busy && q.cnt == '0));

endmodule

// File: rtl/md_fixup.sv
module md_fixup
    import md_pkg::*;
#(
    parameter int W = 32
) (
    input  md_fix_t        fix_i,
    input  logic [2*W-1:0] raw_i,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);

    localparam int W2 = 2 * W;

    logic [W2-1:0] prod;

    always_comb begin
        prod = fix_i.neg_lo ? (W2'(0) - raw_i) : raw_i;
        if (fix_i.is_div) begin
            lo_o = fix_i.neg_lo ? (W'(0) - raw_i[W-1:0])  : raw_i[W-1:0];
            hi_o = fix_i.neg_hi ? (W'(0) - raw_i[W2-1:W]) : raw_i[W2-1:W];
        end else begin
            lo_o = prod[W-1:0];
            hi_o = prod[W2-1:W];
        end
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import md_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         wr_hi_i,
    input  logic         wr_lo_i,
    input  logic [W-1:0] wr_data_i,
    output logic         busy_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);

    localparam int W2 = 2 * W;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } pair_t;

    pair_t         pair_q, pair_d;
    logic [W-1:0]  mag_a, mag_b;
    md_fix_t       fix_in, fix_run;
    logic          busy, done;
    logic [W2-1:0] raw;
    logic [W-1:0]  res_hi, res_lo;

    md_prep #(.W(W)) u_prep (
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .fix_o   (fix_in)
    );

    md_engine #(.W(W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_i),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .fix_i   (fix_in),
        .busy_o  (busy),
        .done_o  (done),
        .raw_o   (raw),
        .fix_o   (fix_run)
    );

    md_fixup #(.W(W)) u_fixup (
        .fix_i (fix_run),
        .raw_i (raw),
        .hi_o  (res_hi),
        .lo_o  (res_lo)
    );

    always_comb begin
        pair_d = pair_q;
        if (done) begin
            pair_d.hi = res_hi;
            pair_d.lo = res_lo;
        end else if (!busy) begin
            if (wr_hi_i) pair_d.hi = wr_data_i;
            if (wr_lo_i) pair_d.lo = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign busy_o = busy;
    assign hi_o   = pair_q.hi;
    assign lo_o   = pair_q.lo;

    // R11 and R9: nothing disturbs the pair before the final iteration
    p_pair_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(hi_o) && $stable(lo_o)));

    // R8: an idle move-to lands on the next edge
    p_move_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_hi_i) |=> (hi_o == $past(wr_data_i)));

    p_move_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_lo_i) |=> (lo_o == $past(wr_data_i)));

    // R10: a start mid-run does not extend or restart the run
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && start_i) |=> !busy_o);

endmodule

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         wr_hi_i = 1'b0;
    logic         wr_lo_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         busy_o;
    logic [W-1:0] hi_o;
    logic [W-1:0] lo_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    muldiv_hilo #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .wr_hi_i   (wr_hi_i),
        .wr_lo_i   (wr_lo_i),
        .wr_data_i (wr_data_i),
        .busy_o    (busy_o),
        .hi_o      (hi_o),
        .lo_o      (lo_o)
    );

    // expected {HI, LO} from the requirements (R3..R6)
    function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            2'b00: begin p = 64'(sa * sb); return p; end
            2'b01: begin p = {32'b0, a} * {32'b0, b}; return p; end
            2'b10: begin q = sa / sb; r = sa % sb; return {r[31:0], q[31:0]}; end
            default: return {a % b, a / b};
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // run one operation; optionally inject a start or a move-to mid-run
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input bit extra_start, input bit extra_move);
        logic [31:0] old_hi, old_lo;
        int          n;
        bit          held;
        old_hi = hi_o;
        old_lo = lo_o;
        held   = 1;
        n      = 0;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        a_i = ~a; b_i = b ^ 32'h5a5a_0001; op_i = ~op;
        while (busy_o && n < 100) begin
            n++;
            if (hi_o !== old_hi || lo_o !== old_lo) held = 0;
            if (n == 10 && extra_start) start_i = 1'b1;
            if (n == 12 && extra_move) begin
                wr_hi_i = 1'b1; wr_lo_i = 1'b1; wr_data_i = 32'hdead_beef;
            end
            if (n == 11) start_i = 1'b0;
            if (n == 13) begin wr_hi_i = 1'b0; wr_lo_i = 1'b0; end
            @(negedge clk);
        end
        start_i = 1'b0; wr_hi_i = 1'b0; wr_lo_i = 1'b0;
        check("R2 busy length", 64'(n), 64'd32);
        check("R11 pair held while busy", 64'(held), 64'd1);
        if (b != 0 || !op[1]) begin
            if (extra_start)
                check("R10 start during run ignored", {hi_o, lo_o}, model(op, a, b));
            else if (extra_move)
                check("R9 move during run ignored", {hi_o, lo_o}, model(op, a, b));
            else if (op == 2'b00)
                check("R4 signed multiply", {hi_o, lo_o}, model(op, a, b));
            else if (op == 2'b01)
                check("R3 unsigned multiply", {hi_o, lo_o}, model(op, a, b));
            else if (op == 2'b10)
                check("R6 signed divide", {hi_o, lo_o}, model(op, a, b));
            else
                check("R5 unsigned divide", {hi_o, lo_o}, model(op, a, b));
        end else begin
            check("R7 divide by zero returns idle", 64'(busy_o), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00c0_ffee));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {31'b0, busy_o, hi_o, lo_o}, 96'b0);

        // R8: move-to while idle, separately and together
        wr_hi_i = 1'b1; wr_data_i = 32'h1234_5678;
        @(negedge clk);
        wr_hi_i = 1'b0;
        check("R8 move to HI", {hi_o, lo_o}, {32'h1234_5678, 32'h0});
        wr_lo_i = 1'b1; wr_data_i = 32'h9abc_def0;
        @(negedge clk);
        wr_lo_i = 1'b0;
        check("R8 move to LO", {hi_o, lo_o}, {32'h1234_5678, 32'h9abc_def0});
        wr_hi_i = 1'b1; wr_lo_i = 1'b1; wr_data_i = 32'h0f0f_0f0f;
        @(negedge clk);
        wr_hi_i = 1'b0; wr_lo_i = 1'b0;
        check("R8 move to both", {hi_o, lo_o}, {32'h0f0f_0f0f, 32'h0f0f_0f0f});

        // directed corners
        run_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, 0, 0);
        run_op(2'b00, 32'hffff_ffff, 32'hffff_ffff, 0, 0);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, 0);
        run_op(2'b00, 32'h8000_0000, 32'h0000_0003, 0, 0);
        run_op(2'b10, 32'hffff_fff9, 32'h0000_0002, 0, 0);
        run_op(2'b10, 32'h0000_0007, 32'hffff_fffe, 0, 0);
        run_op(2'b10, 32'h8000_0000, 32'hffff_ffff, 0, 0);
        run_op(2'b11, 32'hffff_ffff, 32'h0000_0010, 0, 0);
        run_op(2'b11, 32'h0000_0003, 32'h0000_0007, 0, 0);
        run_op(2'b11, 32'h1234_5678, 32'h0000_0000, 0, 0);
        run_op(2'b10, 32'h8000_0000, 32'h0000_0000, 0, 0);
        run_op(2'b01, 32'hcafe_f00d, 32'h0000_0001, 1, 0);
        run_op(2'b10, 32'hffff_ff00, 32'h0000_0007, 0, 1);

        // random mix
        for (int i = 0; i < 200; i++) begin
            logic [1:0]  op;
            logic [31:0] a, b;
            op = 2'($urandom);
            a  = $urandom;
            b  = $urandom;
            if ((i % 7) == 0) b = b >> (($urandom % 31) + 1);
            if ((i % 11) == 0) a = 32'h8000_0000;
            if ((i % 13) == 0) b = 32'hffff_ffff;
            run_op(op, a, b, (i % 9) == 4, (i % 9) == 6);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule